// File: doc/BRIEF.md
# Retriggerable Resettable One-Shot Pulse Generator

This block is a clocked monostable. It watches two trigger pins and, on a qualifying edge, raises a pulse output for a programmable number of clock cycles. A complementary output is also provided. One trigger pin fires on its low-to-high transition and the other on its high-to-low transition. Each pin is gated by the level of the other pin, so the two can also be used together to select which edge counts.

A mode pin selects between two behaviours. In extend mode, a trigger that arrives during a pulse restarts the count without disturbing the output, so a steady trigger stream holds the pulse high. In lock-out mode, such triggers are ignored. An active-low clear ends a pulse in the same cycle and blocks new pulses while it is held. All inputs are expected to be synchronous to the clock already.

There is no data stream, so all pins are plain control and status signals with no handshake.

Top module: `oneshot_gen`

## Requirements
- R1: A rising edge on `trig_rise_i` (low in the previous cycle, high now) while `trig_fall_i` is high is a trigger; `pulse` goes high in the next cycle.
- R2: A falling edge on `trig_fall_i` (high in the previous cycle, low now) while `trig_rise_i` is low is a trigger; `pulse` goes high in the next cycle.
- R3: A rising edge on `trig_rise_i` while `trig_fall_i` is low, a falling edge on `trig_fall_i` while `trig_rise_i` is high, and any opposite-direction edge are not triggers.
- R4: After a trigger accepted from idle, `pulse` stays high for exactly N consecutive cycles and then returns low.
- R5: `pulse_n` is always the inverse of `pulse`.
- R6: With `lockout` = 0, a trigger during a pulse reloads the count with no low cycle on `pulse`; the pulse ends N cycles after the last trigger.
- R7: With `lockout` = 1, triggers during a pulse are ignored; the pulse ends N cycles after the trigger that started it.
- R8: `clr_n` low forces `pulse` low in the same cycle and ends any pulse in progress.
- R9: While `clr_n` is low, no pulse starts. Edges seen during clear are consumed and do not fire after release.
- R10: If `clr_n` is low in the cycle a trigger edge appears, no pulse starts. If `clr_n` is high in that cycle, even right after a clear, the trigger is accepted.
- R11: N is taken from `width_cfg` at each start or reload; changing `width_cfg` later does not change a pulse in progress. A value of 0 gives N = 1.
- R12: Synchronous `srst` makes `pulse` low from the next cycle. It seeds the edge history with the current input levels, so input levels held across reset release cause no trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| trig_rise_i | input | 1 | Trigger on rising edge, qualified by trig_fall_i high |
| trig_fall_i | input | 1 | Trigger on falling edge, qualified by trig_rise_i low |
| clr_n | input | 1 | Direct clear, active low |
| lockout | input | 1 | 0 = extend on retrigger, 1 = ignore retriggers |
| width_cfg | input | WIDTH | Pulse length N in clock cycles |
| pulse | output | 1 | Pulse output, high while timing |
| pulse_n | output | 1 | Complement of pulse |

## Verification
The clear and a trigger edge can land in the same cycle, and they must resolve opposite ways depending on the direction of the clear. The bench raises a trigger edge in a cycle where `clr_n` is low and expects `pulse` to stay low for the following cycles. It then drops `clr_n` one cycle and raises a new edge in the very cycle `clr_n` returns high, and expects a full N-cycle pulse. A retrigger can also land in the cycle a pulse would have ended. The bench provokes this by re-firing during a pulse and checks, cycle by cycle, whether the pulse is extended or ignored according to `lockout`.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    OS_EXTEND  = 1'b0,
    OS_LOCKOUT = 1'b1
  } os_mode_e;
endpackage

// File: rtl/oneshot_edge_detect.sv
module oneshot_edge_detect (
  input  logic clk,
  input  logic srst,
  input  logic rise_i,
  input  logic fall_i,
  output logic trig
);
  logic rise_q, fall_q;
  logic rise_hit, fall_hit;

  // History register; seeded on reset so held levels make no edge.
  always_ff @(posedge clk) begin
    if (srst) begin
      rise_q <= rise_i;
      fall_q <= fall_i;
    end else begin
      rise_q <= rise_i;
      fall_q <= fall_i;
    end
  end

  assign rise_hit = rise_i & ~rise_q & fall_i;
  assign fall_hit = ~fall_i & fall_q & ~rise_i;
  assign trig     = rise_hit | fall_hit;

  // R3
  gate_chk: assert property (@(posedge clk) disable iff (srst)
    trig |-> (rise_i == fall_i));

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             clr_n,
  input  logic             fire,
  input  os_mode_e         mode,
  input  logic [WIDTH-1:0] load_val,
  output logic             active
);
  logic [WIDTH-1:0] cnt;
  logic             reload;

  assign active = (cnt != '0);
  assign reload = fire && (!active || mode == OS_EXTEND);

  always_ff @(posedge clk) begin
    if (srst)          cnt <= '0;
    else if (!clr_n)   cnt <= '0;
    else if (reload)   cnt <= load_val;
    else if (active)   cnt <= cnt - WIDTH'(1);
  end

  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (srst)
    (active && clr_n && !fire) |=> (cnt == $past(cnt) - WIDTH'(1)));

  // R6
  extend_load_chk: assert property (@(posedge clk) disable iff (srst)
    (clr_n && fire && mode == OS_EXTEND) |=> (cnt == $past(load_val)));

  // R7
  lockout_ignore_chk: assert property (@(posedge clk) disable iff (srst)
    (clr_n && fire && active && mode == OS_LOCKOUT) |=> (cnt == $past(cnt) - WIDTH'(1)));

  // R9
  clear_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (!clr_n) |=> (cnt == '0));

endmodule

// File: rtl/oneshot_gen.sv
module oneshot_gen
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             trig_rise_i,
  input  logic             trig_fall_i,
  input  logic             clr_n,
  input  logic             lockout,
  input  logic [WIDTH-1:0] width_cfg,
  output logic             pulse,
  output logic             pulse_n
);
  localparam logic [WIDTH-1:0] MIN_LEN = WIDTH'(1);

  logic             fire;
  logic             active;
  logic [WIDTH-1:0] load_val;
  os_mode_e         mode;

  assign mode     = os_mode_e'(lockout);
  assign load_val = (width_cfg == '0) ? MIN_LEN : width_cfg;

  oneshot_edge_detect u_edge (
    .clk    (clk),
    .srst   (srst),
    .rise_i (trig_rise_i),
    .fall_i (trig_fall_i),
    .trig   (fire)
  );

  oneshot_timer #(.WIDTH(WIDTH)) u_timer (
    .clk      (clk),
    .srst     (srst),
    .clr_n    (clr_n),
    .fire     (fire),
    .mode     (mode),
    .load_val (load_val),
    .active   (active)
  );

  // Clear gates the output directly so it takes effect in the same cycle.
  assign pulse   = active & clr_n;
  assign pulse_n = ~pulse;

  // R8
  clear_out_chk: assert property (@(posedge clk) disable iff (srst)
    (!clr_n) |-> (!pulse && pulse_n));

endmodule

// File: tb/oneshot_gen_test.sv
`timescale 1ns/100ps
module oneshot_gen_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         srst = 1'b1;
  logic         rise_i = 1'b0;
  logic         fall_i = 1'b1;
  logic         clr_n = 1'b1;
  logic         lockout = 1'b0;
  logic [W-1:0] width_cfg = W'(4);
  logic         pulse, pulse_n;

  logic         rst_v = 1'b1;
  logic         mode_v = 1'b0;
  logic [W-1:0] cfg_v = W'(4);
  int           tests = 0;
  int           fails = 0;
  bit           done = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  oneshot_gen #(.WIDTH(W)) uut (
    .clk(clk), .srst(srst), .trig_rise_i(rise_i), .trig_fall_i(fall_i),
    .clr_n(clr_n), .lockout(lockout), .width_cfg(width_cfg),
    .pulse(pulse), .pulse_n(pulse_n)
  );

  // Driver: one call per cycle, pushes the pulse level expected in that cycle.
  task automatic step(input logic r, input logic f, input logic c,
                      input bit e, input string t);
    @(posedge clk);
    #1;
    rise_i = r; fall_i = f; clr_n = c;
    srst = rst_v; lockout = mode_v; width_cfg = cfg_v;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic hold(input logic r, input logic f, input logic c,
                      input bit e, input string t, input int n);
    for (int i = 0; i < n; i++) step(r, f, c, e, t);
  endtask

  // Monitor: compare in mid-cycle, away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (pulse !== e) begin
        fails++;
        $display("FAIL %s pulse actual=%b expected=%b at %0t", t, pulse, e, $time);
      end
      tests++;
      if (pulse_n !== ~e) begin
        fails++;
        $display("FAIL R5 pulse_n actual=%b expected=%b at %0t", pulse_n, ~e, $time);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R12: change levels during reset, then release: no false edge
    step(1, 1, 1, 0, "R12");
    rst_v = 1'b0;
    hold(1, 1, 1, 0, "R12", 3);
    step(0, 1, 1, 0, "R12");

    // R1 / R4: rising trigger, width 4
    step(1, 1, 1, 0, "R1");
    hold(1, 1, 1, 1, "R4", 4);
    step(1, 1, 1, 0, "R4");
    hold(0, 1, 1, 0, "R4", 2);

    // R2: falling trigger
    step(0, 0, 1, 0, "R2");
    hold(0, 0, 1, 1, "R2", 4);
    step(0, 0, 1, 0, "R4");
    hold(0, 1, 1, 0, "R2", 2);

    // R3: gated and opposite-direction edges
    step(1, 0, 1, 0, "R3");
    step(1, 0, 1, 0, "R3");
    step(0, 0, 1, 0, "R3");
    step(1, 0, 1, 0, "R3");
    step(1, 0, 1, 0, "R3");
    step(1, 1, 1, 0, "R3");
    step(1, 0, 1, 0, "R3");
    step(1, 0, 1, 0, "R3");
    step(0, 0, 1, 0, "R3");
    hold(0, 1, 1, 0, "R3", 2);

    // R6: retrigger extends
    step(1, 1, 1, 0, "R6");
    step(0, 1, 1, 1, "R6");
    step(1, 1, 1, 1, "R6");
    hold(1, 1, 1, 1, "R6", 4);
    step(1, 1, 1, 0, "R6");
    step(0, 1, 1, 0, "R6");

    // R7: lock-out ignores retrigger
    mode_v = 1'b1;
    step(1, 1, 1, 0, "R7");
    step(0, 1, 1, 1, "R7");
    step(1, 1, 1, 1, "R7");
    hold(1, 1, 1, 1, "R7", 2);
    step(1, 1, 1, 0, "R7");
    step(0, 1, 1, 0, "R7");
    mode_v = 1'b0;

    // R8 / R9: clear mid-pulse, then triggers while held
    step(1, 1, 1, 0, "R1");
    step(1, 1, 1, 1, "R4");
    step(1, 1, 0, 0, "R8");
    step(1, 1, 1, 0, "R8");
    step(0, 1, 0, 0, "R9");
    hold(1, 1, 0, 0, "R9", 2);
    hold(1, 1, 1, 0, "R9", 2);
    step(0, 1, 1, 0, "R9");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, "R9");
    step(0, 1, 1, 0, "R9");

    // R10: clear coincident with edge, then release coincident with edge
    step(1, 1, 0, 0, "R10");
    hold(1, 1, 1, 0, "R10", 2);
    step(0, 1, 0, 0, "R10");
    step(1, 1, 1, 0, "R10");
    hold(1, 1, 1, 1, "R10", 4);
    step(1, 1, 1, 0, "R10");
    step(0, 1, 1, 0, "R10");

    // R11: width sampled at start; zero means one
    cfg_v = W'(3);
    step(1, 1, 1, 0, "R11");
    cfg_v = W'(7);
    hold(1, 1, 1, 1, "R11", 3);
    step(1, 1, 1, 0, "R11");
    step(0, 1, 1, 0, "R11");
    cfg_v = W'(0);
    step(1, 1, 1, 0, "R11");
    step(1, 1, 1, 1, "R11");
    step(1, 1, 1, 0, "R11");
    step(0, 1, 1, 0, "R11");
    cfg_v = W'(4);

    // R12: reset during a pulse
    step(1, 1, 1, 0, "R1");
    step(1, 1, 1, 1, "R4");
    rst_v = 1'b1;
    step(1, 1, 1, 1, "R12");
    rst_v = 1'b0;
    hold(1, 1, 1, 0, "R12", 2);

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule